// File: doc/BRIEF.md
# DDR3 Read-Return Latency Tracker

This block sits on the controller side of a DDR3 command bus. It observes the chip-select, row-strobe, column-strobe and write-enable pins on each clock edge and classifies the command as a deselect, a no-operation, a READ or a mode-register write. From the mode-register writes it keeps its own copy of the device's CAS latency, additive latency, CAS write latency and DLL enable. From these it derives the number of cycles between a READ and the first returned data.

For every READ, the block loads a marker into a latency shift register. When the marker reaches the output, a one-cycle `burst_first_beat` pulse is raised and `data_expected` is held high for the four clock cycles of an eight-beat burst. Several reads can be in flight together. When the device DLL is disabled, the return point moves one cycle earlier. A DLL-off configuration that uses any latency other than 6 sets a sticky error flag.

Top module: `rd_return_tracker`

## Requirements
- R1: After reset, `data_expected`, `burst_first_beat`, `dll_off` and `illegal_cfg` are 0, and `rd_latency` is 6 (CL=6, AL=0, CWL=6, DLL on).
- R2: Each command is sampled on a rising clock edge, with the following encodings:
  - A deselect is `cs_n`=1, whatever the other pins are.
  - A no-operation is `cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1.
  - A READ is 0,1,0,1.
  - A mode-register write is 0,0,0,0. `ba[1:0]` selects register 0 to 3. A write to register 3 changes no tracked setting.
- R3: A deselect or no-operation starts no data window, changes no setting, and does not disturb a window already in flight.
- R4: With the DLL on, for a READ sampled at edge k, `burst_first_beat` is high only in the cycle after edge k+AL+CL.
- R5: With the DLL off, the first beat comes one cycle earlier, after edge k+AL+CL-1.
- R6: `data_expected` is high for exactly the four cycles that start with the first-beat cycle of each READ, and is low otherwise.
- R7: READs spaced four cycles apart produce contiguous windows. Each READ still gets its own first-beat pulse.
- R8: In a write to register 0, `addr[6:4]` holds a code and CL = code + 4.
- R9: In a write to register 1:
  - `addr[0]`=1 disables the DLL and `addr[0]`=0 enables it.
  - `addr[4:3]` selects AL: 0 gives 0, 1 gives CL-1, 2 gives CL-2, and 3 gives 0.
- R10: In a write to register 2, `addr[5:3]` holds a code and CWL = code + 5.
- R11: While the DLL is off, any CL other than 6 or any CWL other than 6 sets `illegal_cfg` two edges after the write that creates the condition. The flag then stays set until reset.
- R12: `rd_latency` shows the current read latency: AL+CL with the DLL on, and AL+CL-1 with it off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address; low two bits pick the mode register |
| addr | input | 14 | Address bus carrying mode-register fields |
| data_expected | output | 1 | High during each expected four-cycle data window |
| burst_first_beat | output | 1 | One-cycle pulse on the first cycle of a window |
| dll_off | output | 1 | Tracked DLL-disabled state |
| rd_latency | output | 5 | Current effective read latency in cycles |
| illegal_cfg | output | 1 | Sticky flag for an unsupported DLL-off latency |

## Verification
The pipeline assertions assume two things about the command stream. Each first-beat pulse stands alone, which holds only if READs are at least four cycles apart. The latency must also not shrink while an earlier READ is still in flight. The stimulus meets both conditions. It spaces every READ group at four cycles or more, and it lets the pipeline drain before issuing any mode-register write. The mode-register checks assume that settings move only on a decoded write. The stimulus tests this by placing write-like pin patterns under a high chip select and under a no-operation during live windows.

// File: rtl/rrt_pkg.sv
// Package rrt_pkg
// Shared command encoding and tracked mode-register state for the
// read-return latency tracker. Assumes a DDR3-style active-low command bus.
package rrt_pkg;

    typedef enum logic [2:0] {
        CMD_DES   = 3'd0,
        CMD_NOP   = 3'd1,
        CMD_READ  = 3'd2,
        CMD_MRS   = 3'd3,
        CMD_OTHER = 3'd4
    } rrt_cmd_e;

    typedef struct packed {
        logic       dll_off;
        logic [3:0] cl;
        logic [3:0] cwl;
        logic [1:0] al_code;
    } rrt_mode_t;

    localparam logic [3:0] DEF_CL       = 4'd6;
    localparam logic [3:0] DEF_CWL      = 4'd6;
    localparam logic [3:0] CL_CODE_BASE = 4'd4;
    localparam logic [3:0] CWL_CODE_BASE = 4'd5;

endpackage

// File: rtl/rrt_cmd_decode.sv
// Module rrt_cmd_decode
// Classifies the sampled command pins into one command kind.
// Assumes active-low pins. A high chip select always means deselect.
module rrt_cmd_decode
    import rrt_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output rrt_cmd_e cmd
);

    // Purpose: map the four strobe pins to a command kind.
    always_comb begin
        if (cs_n)
            cmd = CMD_DES;
        else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b101:  cmd = CMD_READ;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/rrt_mode_regs.sv
// Module rrt_mode_regs
// Holds the latency-related mode-register fields, derives the effective
// read latency, and flags an unsupported latency while the DLL is off.
// Assumes the register field layout given in the brief (R8-R10).
module rrt_mode_regs
    import rrt_pkg::*;
#(
    parameter int LAT_W  = 5,
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_en,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] addr,
    output rrt_mode_t         mode,
    output logic [LAT_W-1:0]  latency,
    output logic              illegal_cfg
);

    logic [LAT_W-1:0] al_val;
    logic [LAT_W-1:0] cl_ext;
    logic             bad_now;

    // Purpose: capture mode-register fields on a decoded register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode.dll_off <= 1'b0;
            mode.cl      <= DEF_CL;
            mode.cwl     <= DEF_CWL;
            mode.al_code <= 2'd0;
        end else if (mrs_en) begin
            case (reg_sel)
                2'd0: mode.cl <= {1'b0, addr[6:4]} + CL_CODE_BASE;
                2'd1: begin
                    mode.dll_off <= addr[0];
                    mode.al_code <= addr[4:3];
                end
                2'd2: mode.cwl <= {1'b0, addr[5:3]} + CWL_CODE_BASE;
                default: ;
            endcase
        end
    end

    // Purpose: derive additive latency and the effective read latency.
    always_comb begin
        cl_ext = LAT_W'(mode.cl);
        case (mode.al_code)
            2'd1:    al_val = cl_ext - LAT_W'(1);
            2'd2:    al_val = cl_ext - LAT_W'(2);
            default: al_val = '0;
        endcase
        latency = al_val + cl_ext - LAT_W'(mode.dll_off);
    end

    assign bad_now = mode.dll_off && ((mode.cl != DEF_CL) || (mode.cwl != DEF_CWL));

    // Purpose: latch the sticky unsupported-configuration flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            illegal_cfg <= 1'b0;
        else if (bad_now)
            illegal_cfg <= 1'b1;
    end

    AST_CFG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_cfg |=> illegal_cfg); // R11
    AST_DLLOFF_BAD_CL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.dll_off && mode.cl != DEF_CL) |=> illegal_cfg); // R11
    AST_HOLD_WITHOUT_MRS: assert property (@(posedge clk) disable iff (!rst_n)
        !mrs_en |=> $stable(mode)); // R3

endmodule

// File: rtl/rrt_latency_pipe.sv
// Module rrt_latency_pipe
// Shift register that carries one marker per READ toward the output.
// It raises the first-beat pulse and a four-cycle data window.
// Assumes launches are at least four cycles apart and latency < DEPTH.
module rrt_latency_pipe #(
    parameter int DEPTH   = 22,
    parameter int LAT_W   = 5,
    parameter int WIN_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [LAT_W-1:0] lat,
    output logic             first_beat,
    output logic             window
);

    localparam int HIST_W = WIN_LEN - 1;

    logic [DEPTH-1:0]  stage_q;
    logic [DEPTH-1:0]  stage_d;
    logic [HIST_W-1:0] tail_q;

    // Purpose: advance all markers one stage and insert a new one at the latency slot.
    always_comb begin
        stage_d = stage_q >> 1;
        if (launch && (int'(lat) < DEPTH))
            stage_d[lat] = 1'b1;
    end

    // Purpose: register the marker chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else
            stage_q <= stage_d;
    end

    // Purpose: remember recent first beats to stretch the window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tail_q <= '0;
        else
            tail_q <= {tail_q[HIST_W-2:0], stage_q[0]};
    end

    assign first_beat = stage_q[0];
    assign window     = stage_q[0] | (|tail_q);

    AST_WINDOW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        first_beat |=> window); // R6
    AST_SINGLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        first_beat |=> !first_beat); // R7

endmodule

// File: rtl/rd_return_tracker.sv
// Module rd_return_tracker
// Top level. It decodes the command bus, tracks the latency settings and
// predicts when read data returns for each READ, in DLL-on or DLL-off mode.
// Assumes a BL8 burst and commands sampled on every rising clock edge.
module rd_return_tracker
    import rrt_pkg::*;
#(
    parameter int MAX_CL = 11,
    parameter int ADDR_W = 14,
    parameter int BA_W   = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_n,
    input  logic                         ras_n,
    input  logic                         cas_n,
    input  logic                         we_n,
    input  logic [BA_W-1:0]              ba,
    input  logic [ADDR_W-1:0]            addr,
    output logic                         data_expected,
    output logic                         burst_first_beat,
    output logic                         dll_off,
    output logic [$clog2(2*MAX_CL)-1:0]  rd_latency,
    output logic                         illegal_cfg
);

    localparam int DEPTH = 2 * MAX_CL;
    localparam int LAT_W = $clog2(DEPTH);

    rrt_cmd_e         cmd;
    rrt_mode_t        mode;
    logic [LAT_W-1:0] lat;
    logic             launch;
    logic             mrs_en;
    logic             pins_unused;

    assign pins_unused = ^{addr[ADDR_W-1:7], ba[BA_W-1:2]};

    rrt_cmd_decode u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    assign launch = (cmd == CMD_READ);
    assign mrs_en = (cmd == CMD_MRS);

    rrt_mode_regs #(
        .LAT_W  (LAT_W),
        .ADDR_W (ADDR_W)
    ) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .mrs_en      (mrs_en),
        .reg_sel     (ba[1:0]),
        .addr        (addr),
        .mode        (mode),
        .latency     (lat),
        .illegal_cfg (illegal_cfg)
    );

    rrt_latency_pipe #(
        .DEPTH   (DEPTH),
        .LAT_W   (LAT_W),
        .WIN_LEN (4)
    ) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .lat        (lat),
        .first_beat (burst_first_beat),
        .window     (data_expected)
    );

    assign dll_off    = mode.dll_off;
    assign rd_latency = lat;

    AST_DES_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(rd_latency)); // R3

endmodule

// File: tb/rd_return_tracker_bench.sv
`timescale 1ns/1ps
module rd_return_tracker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [2:0]  ba = '0;
    logic [13:0] addr = '0;
    logic        data_expected, burst_first_beat, dll_off, illegal_cfg;
    logic [4:0]  rd_latency;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;
    int exp_q[$];
    int starts[$];

    // bench model of the latency settings
    int m_cl = 6, m_al_code = 0;
    bit m_dll_off = 1'b0;

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    rd_return_tracker u_rd_return_tracker (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .data_expected(data_expected),
        .burst_first_beat(burst_first_beat), .dll_off(dll_off),
        .rd_latency(rd_latency), .illegal_cfg(illegal_cfg)
    );

    function automatic int model_lat();
        int al;
        al = (m_al_code == 1) ? m_cl - 1 : (m_al_code == 2) ? m_cl - 2 : 0;
        return al + m_cl - (m_dll_off ? 1 : 0);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic drive(input logic c, input logic r, input logic ca, input logic w,
                         input logic [2:0] b, input logic [13:0] a);
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
    endtask

    task automatic idle(input int n);
        repeat (n) drive(1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 14'd0);
    endtask

    task automatic mrs(input logic [2:0] b, input logic [13:0] a);
        drive(1'b0, 1'b0, 1'b0, 1'b0, b, a);
        case (b[1:0])
            2'd0: m_cl = int'(a[6:4]) + 4;
            2'd1: begin m_dll_off = a[0]; m_al_code = int'(a[4:3]); end
            default: ;
        endcase
    endtask

    // driver: issue a READ and push its expected first-beat cycle
    task automatic rd();
        drive(1'b0, 1'b1, 1'b0, 1'b1, 3'd0, 14'd0);
        exp_q.push_back(cyc + model_lat() + 1);
        starts.push_back(cyc + model_lat() + 1);
    endtask

    // monitor: pop expected first beats and compare the window every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_win;
            exp_win = 1'b0;
            foreach (starts[i])
                if (cyc >= starts[i] && cyc <= starts[i] + 3) exp_win = 1'b1;
            if (burst_first_beat) begin
                if (exp_q.size() == 0)
                    check(1'b0, "R3/R4 unexpected first beat", 1, 0);
                else
                    check(exp_q.pop_front() == cyc, "R4/R5 first-beat cycle", cyc, cyc);
            end else if (exp_q.size() != 0 && exp_q[0] < cyc) begin
                check(1'b0, "R4/R5/R7 missing first beat", cyc, exp_q.pop_front());
            end
            if (data_expected !== exp_win)
                check(1'b0, "R6/R7 data window", int'(data_expected), int'(exp_win));
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cs_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_cl = 6; m_al_code = 0; m_dll_off = 1'b0;
        starts.delete();
    endtask

    initial begin
        #(20ns * 100000);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "all watchdog expired", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        idle(1);
        // R1 reset state
        check(data_expected == 0 && burst_first_beat == 0, "R1 outputs idle", int'(data_expected), 0);
        check(dll_off == 0, "R1 dll_off", int'(dll_off), 0);
        check(illegal_cfg == 0, "R1 illegal_cfg", int'(illegal_cfg), 0);
        check(rd_latency == 6, "R1 rd_latency", int'(rd_latency), 6);

        // R4 single read, default latency 6
        rd(); idle(15);

        // R8 CL code 3 -> CL 7; R12 latency shows it
        mrs(3'd0, 14'd3 << 4); idle(1);
        check(rd_latency == 7, "R8 R12 CL=7 latency", int'(rd_latency), 7);
        rd(); idle(15);

        // R9 AL code 1 -> AL = CL-1 = 6, latency 13
        mrs(3'd1, 14'd1 << 3); idle(1);
        check(rd_latency == 13, "R9 AL=CL-1 latency", int'(rd_latency), 13);
        rd(); idle(20);

        // R7 back-to-back reads; R3 deselect/NOP with write-like pins in flight
        rd(); idle(3); rd(); idle(3); rd();
        drive(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 14'd7 << 4);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 3'd1, 14'd1);
        idle(1);
        check(rd_latency == 13 && dll_off == 0, "R3 settings unchanged by DES/NOP", int'(rd_latency), 13);
        idle(25);

        // R2 register 3 write changes nothing
        mrs(3'd3, 14'h3fff); idle(1);
        check(rd_latency == 13 && dll_off == 0, "R2 register 3 ignored", int'(rd_latency), 13);

        // R5 DLL off with CL=6, AL=0 -> latency 5; R10 reset CWL=6 is legal
        mrs(3'd0, 14'd2 << 4); idle(1);
        mrs(3'd1, 14'd1); idle(2);
        check(dll_off == 1, "R9 DLL off bit", int'(dll_off), 1);
        check(rd_latency == 5, "R5 R12 DLL-off latency", int'(rd_latency), 5);
        check(illegal_cfg == 0, "R10 R11 legal DLL-off config", int'(illegal_cfg), 0);
        rd(); idle(12);

        // R5 DLL off with AL=CL-1 -> 5+6-1 = 10
        mrs(3'd1, 14'd1 | (14'd1 << 3)); idle(1);
        check(rd_latency == 10, "R5 DLL-off with AL", int'(rd_latency), 10);
        rd(); idle(3); rd(); idle(20);

        // R10 R11 CWL code 2 -> 7 while DLL off -> sticky flag
        mrs(3'd2, 14'd2 << 3); idle(2);
        check(illegal_cfg == 1, "R11 CWL=7 with DLL off", int'(illegal_cfg), 1);
        mrs(3'd2, 14'd1 << 3); idle(3);
        check(illegal_cfg == 1, "R11 flag sticky", int'(illegal_cfg), 1);

        // DLL back on
        mrs(3'd1, 14'd0); idle(1);
        check(dll_off == 0 && rd_latency == 6, "R9 R12 DLL on again", int'(rd_latency), 6);
        rd(); idle(15);

        // R1 reset clears the flag
        do_reset(); idle(1);
        check(illegal_cfg == 0 && rd_latency == 6, "R1 reset clears flag", int'(illegal_cfg), 0);
        check(exp_q.size() == 0, "R4 all bursts seen", exp_q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule